// File: doc/BRIEF.md
# Alignment-Aware Translation Lookaside Checker

This block sits on the data-access path of a 64-bit paged processor core. For every access it receives a linear address, an access width (1, 2, 4 or 8 bytes), an access kind (read, write or read-modify-write), the current privilege level, a stack flag and a 64-bit-mode flag. It looks the page up in a small direct-mapped translation buffer. One cycle later it answers with exactly one outcome. The outcome is a fast-path hit with a physical address, a slow-path request, or one fault out of general-protection, stack-segment and alignment-check.

The block holds the alignment-check state itself. The state is a check-mask register that is all ones when checking is on and the page-frame mask when it is off. The mask is folded into the lookup tag. A misaligned access made while checking is on therefore keeps nonzero low bits in its tag and can never match a page-aligned stored tag. Such an access falls through to the slow path. There the canonical-address test is applied before the alignment test. Refills and a global invalidate come in through a plain write port; page walking and the refill policy are left to the surrounding logic.

Top module: `acg_top`

## Requirements
- R1: After reset every response output is 0, `ac_on` is 0, and no entry is valid, so any access gives `rsp_miss`.
- R2: On a `mode_upd` cycle, checking turns on (`ac_on`=1 from the next cycle) only if `mode_cpl`=3, `mode_am`=1 and `mode_ac`=1 together; any other combination turns it off. Without a mode event the state holds.
- R3: A `mode_sysent` pulse (fast system entry, fast system call, system-management entry) turns checking off from the next cycle, and it wins over a `mode_upd` in the same cycle.
- R4: A request whose page number equals a valid entry's stored page number, at the entry picked by address bits 15:12, gives `rsp_hit` with `rsp_paddr` = {entry frame, address bits 11:0}.
- R5: A write (`req_kind`=01) or read-modify-write (`req_kind`=10 or 11) hits only if permission bit (4 + `req_cpl`) of the entry is set; otherwise it goes to the slow path. A read (`req_kind`=00) needs no permission bit.
- R6: While checking is on, an access whose address has any of the size-mask bits set never hits (the size mask is 1 for 2 bytes, 3 for 4 bytes and 7 for 8 bytes). Aligned accesses still hit. While checking is off, misaligned accesses hit normally.
- R7: A slow-path access that passes the canonical test, or is not subject to it, raises the alignment fault (`rsp_fault` bit 2) when checking is on and the address ANDed with the size mask is nonzero.
- R8: One-byte accesses (`req_size`=00) use a size mask of 0 and never raise the alignment fault.
- R9: An address is canonical when bits 63 down to 47 are all equal. The test applies when `req_long`=1, or when `req_stack`=1 with an 8-byte size. A failing access raises the stack fault (bit 1) if `req_stack`=1, else the general-protection fault (bit 0), and then never raises the alignment fault.
- R10: The outputs are registered and appear in the cycle after the request. For each request exactly one of `rsp_hit`, `rsp_miss` and the three `rsp_fault` bits is set, and none of them is set in a cycle after no request.
- R11: `fill_en` writes page number, frame and permissions into the entry picked by the low 4 bits of `fill_page`. `flush_all` clears every valid bit in one cycle and wins over a fill in the same cycle.
- R12: Filling a page that maps to an occupied index replaces that entry, so the old page then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_addr | input | 64 | Linear address |
| req_size | input | 2 | Width code: 00=1, 01=2, 10=4, 11=8 bytes |
| req_kind | input | 2 | 00 read, 01 write, 10/11 read-modify-write |
| req_cpl | input | 2 | Current privilege level |
| req_stack | input | 1 | Access goes through the stack segment |
| req_long | input | 1 | Access made in 64-bit mode |
| mode_upd | input | 1 | Re-evaluate alignment-check state |
| mode_cpl | input | 2 | Privilege level for the re-evaluation |
| mode_am | input | 1 | Alignment-mask control bit |
| mode_ac | input | 1 | Alignment-check flag |
| mode_sysent | input | 1 | System-entry event; disables checking |
| fill_en | input | 1 | Write one entry |
| fill_page | input | 52 | Page number (address bits 63:12) |
| fill_frame | input | 40 | Physical frame number |
| fill_perm | input | 8 | Permission bits; bit 4+CPL grants writes |
| flush_all | input | 1 | Invalidate every entry |
| rsp_hit | output | 1 | Fast-path hit |
| rsp_miss | output | 1 | Slow-path request |
| rsp_paddr | output | 52 | Physical address on a hit |
| rsp_fault | output | 3 | One-hot: bit0 general protection, bit1 stack, bit2 alignment |
| ac_on | output | 1 | Alignment checking enabled |

## Verification
On every cycle the assertions check the following: a response carries exactly one outcome; a misaligned access with checking on never hits; byte accesses never raise the alignment fault; a non-canonical access never reaches the alignment test. They also check that system-entry and non-qualifying mode updates switch checking off, and that a flush leaves nothing to hit. The concrete physical address, the write-permission selection by privilege level, the choice between stack and general-protection faults, and the replacement of a conflicting entry depend on the values that were filled. Only the bench's directed scenarios can show these.

// File: rtl/acg_pkg.sv
package acg_pkg;

  typedef enum logic [1:0] {
    SZ_B1 = 2'b00,
    SZ_B2 = 2'b01,
    SZ_B4 = 2'b10,
    SZ_B8 = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic hit;
    logic miss;
    logic f_align;
    logic f_stack;
    logic f_gp;
  } outcome_t;

  // Low-address bits that must be zero for a naturally aligned access.
  function automatic logic [2:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_B2:   size_mask = 3'b001;
      SZ_B4:   size_mask = 3'b011;
      SZ_B8:   size_mask = 3'b111;
      default: size_mask = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/acg_mode_reg.sv
module acg_mode_reg #(
  parameter int VA_W   = 64,
  parameter int PAGE_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [1:0]      cpl,
  input  logic            am,
  input  logic            ac,
  input  logic            sysent,
  output logic [VA_W-1:0] mask,
  output logic            enabled
);
  localparam logic [VA_W-1:0] PF_MASK = {{(VA_W-PAGE_W){1'b1}}, {PAGE_W{1'b0}}};

  logic [VA_W-1:0] mask_q, mask_d;
  logic            mask_en;

  always_comb begin
    mask_en = upd | sysent;
    if (sysent)
      mask_d = PF_MASK;
    else if (cpl == 2'd3 && am && ac)
      mask_d = '1;
    else
      mask_d = PF_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= PF_MASK;
    else if (mask_en)
      mask_q <= mask_d;
  end

  assign mask    = mask_q;
  assign enabled = mask_q[0];

  a_r3_sysent_disables: assert property (@(posedge clk) disable iff (!rst_n)
    sysent |=> !enabled);

  a_r2_enable_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !(cpl == 2'd3 && am && ac)) |=> !enabled);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !sysent) |=> $stable(enabled));

endmodule

// File: rtl/acg_tlb_array.sv
module acg_tlb_array #(
  parameter int VA_W    = 64,
  parameter int PAGE_W  = 12,
  parameter int FRAME_W = 40,
  parameter int ENTRIES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fill_en,
  input  logic [VA_W-PAGE_W-1:0] fill_page,
  input  logic [FRAME_W-1:0]     fill_frame,
  input  logic [7:0]             fill_perm,
  input  logic                   flush_all,
  input  logic [VA_W-1:0]        look_tag,
  output logic                   match,
  output logic [FRAME_W-1:0]     frame,
  output logic [7:0]             perm
);
  localparam int PN_W  = VA_W - PAGE_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q;
  logic [PN_W-1:0]    tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [7:0]         perm_q  [ENTRIES];

  logic [IDX_W-1:0] wr_idx, rd_idx;
  assign wr_idx = fill_page[IDX_W-1:0];
  assign rd_idx = look_tag[PAGE_W +: IDX_W];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic wr_en;
    logic valid_d;
    assign wr_en   = fill_en && (wr_idx == IDX_W'(e));
    assign valid_d = flush_all ? 1'b0 : (wr_en ? 1'b1 : valid_q[e]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        valid_q[e] <= 1'b0;
      else if (flush_all || wr_en)
        valid_q[e] <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        tag_q[e]   <= fill_page;
        frame_q[e] <= fill_frame;
        perm_q[e]  <= fill_perm;
      end
    end
  end

  // Stored tags are page aligned; any low bit left in the lookup tag misses.
  assign match = valid_q[rd_idx]
              && (tag_q[rd_idx] == look_tag[VA_W-1:PAGE_W])
              && (look_tag[PAGE_W-1:0] == '0);
  assign frame = frame_q[rd_idx];
  assign perm  = perm_q[rd_idx];

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !match);

endmodule

// File: rtl/acg_classify.sv
module acg_classify
  import acg_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int CANON_MSB = 47
) (
  input  logic            match,
  input  logic [7:0]      perm,
  input  logic            is_write,
  input  logic [1:0]      cpl,
  input  logic [VA_W-1:0] addr,
  input  logic [2:0]      smask,
  input  logic            ac_en,
  input  logic            chk_canon,
  input  logic            stack,
  output outcome_t        res
);
  logic wr_ok, canon_ok, misaligned;
  logic [VA_W-1-CANON_MSB:0] hi;

  assign hi        = addr[VA_W-1:CANON_MSB];
  assign canon_ok  = (&hi) | ~(|hi);
  assign wr_ok     = !is_write || perm[{1'b1, cpl}];
  assign misaligned = |(addr[2:0] & smask);

  always_comb begin
    res = '0;
    if (match && wr_ok)
      res.hit = 1'b1;
    else if (chk_canon && !canon_ok) begin
      res.f_stack = stack;
      res.f_gp    = !stack;
    end else if (ac_en && misaligned)
      res.f_align = 1'b1;
    else
      res.miss = 1'b1;
  end

endmodule

// File: rtl/acg_top.sv
module acg_top
  import acg_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PAGE_W    = 12,
  parameter int FRAME_W   = 40,
  parameter int ENTRIES   = 16,
  parameter int CANON_MSB = 47
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [VA_W-1:0]           req_addr,
  input  logic [1:0]                req_size,
  input  logic [1:0]                req_kind,
  input  logic [1:0]                req_cpl,
  input  logic                      req_stack,
  input  logic                      req_long,
  input  logic                      mode_upd,
  input  logic [1:0]                mode_cpl,
  input  logic                      mode_am,
  input  logic                      mode_ac,
  input  logic                      mode_sysent,
  input  logic                      fill_en,
  input  logic [VA_W-PAGE_W-1:0]    fill_page,
  input  logic [FRAME_W-1:0]        fill_frame,
  input  logic [7:0]                fill_perm,
  input  logic                      flush_all,
  output logic                      rsp_hit,
  output logic                      rsp_miss,
  output logic [FRAME_W+PAGE_W-1:0] rsp_paddr,
  output logic [2:0]                rsp_fault,
  output logic                      ac_on
);
  localparam int PA_W = FRAME_W + PAGE_W;
  localparam logic [VA_W-1:0] PF_MASK = {{(VA_W-PAGE_W){1'b1}}, {PAGE_W{1'b0}}};

  logic [VA_W-1:0]    chk_mask, look_tag;
  logic [2:0]         smask;
  logic               match;
  logic [FRAME_W-1:0] ent_frame;
  logic [7:0]         ent_perm;
  outcome_t           res;
  logic               chk_canon;

  acg_mode_reg #(.VA_W(VA_W), .PAGE_W(PAGE_W)) i_mode (
    .clk(clk), .rst_n(rst_n), .upd(mode_upd), .cpl(mode_cpl),
    .am(mode_am), .ac(mode_ac), .sysent(mode_sysent),
    .mask(chk_mask), .enabled(ac_on)
  );

  assign smask    = size_mask(req_size);
  assign look_tag = (req_addr & (PF_MASK | VA_W'(smask))) & chk_mask;

  acg_tlb_array #(.VA_W(VA_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .ENTRIES(ENTRIES)) i_tlb (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_page(fill_page),
    .fill_frame(fill_frame), .fill_perm(fill_perm), .flush_all(flush_all),
    .look_tag(look_tag), .match(match), .frame(ent_frame), .perm(ent_perm)
  );

  assign chk_canon = req_long || (req_stack && req_size == SZ_B8);

  acg_classify #(.VA_W(VA_W), .CANON_MSB(CANON_MSB)) i_cls (
    .match(match), .perm(ent_perm), .is_write(req_kind != 2'b00), .cpl(req_cpl),
    .addr(req_addr), .smask(smask), .ac_en(ac_on), .chk_canon(chk_canon),
    .stack(req_stack), .res(res)
  );

  // Response register: next-state and storage kept apart.
  outcome_t       out_d, out_q;
  logic [PA_W-1:0] pa_d, pa_q;

  always_comb begin
    out_d = req_valid ? res : '0;
    pa_d  = (req_valid && res.hit) ? {ent_frame, req_addr[PAGE_W-1:0]} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      pa_q  <= '0;
    end else begin
      out_q <= out_d;
      pa_q  <= pa_d;
    end
  end

  assign rsp_hit   = out_q.hit;
  assign rsp_miss  = out_q.miss;
  assign rsp_fault = {out_q.f_align, out_q.f_stack, out_q.f_gp};
  assign rsp_paddr = pa_q;

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_hit && !rsp_miss && rsp_fault == 3'b000);

  a_r6_misaligned_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ac_on && (req_addr[2:0] & smask) != 3'b000) |=> !rsp_hit);

  a_r8_byte_no_align: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == SZ_B1) |=> !rsp_fault[2]);

  a_r9_canon_before_align: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_long && !(req_addr[VA_W-1:CANON_MSB] == '0 ||
                                req_addr[VA_W-1:CANON_MSB] == '1)) |=> !rsp_fault[2]);

endmodule

// File: tb/test_acg_top.sv
module test_acg_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_stack, req_long;
  logic [63:0] req_addr;
  logic [1:0]  req_size, req_kind, req_cpl;
  logic        mode_upd, mode_am, mode_ac, mode_sysent;
  logic [1:0]  mode_cpl;
  logic        fill_en, flush_all;
  logic [51:0] fill_page;
  logic [39:0] fill_frame;
  logic [7:0]  fill_perm;
  logic        rsp_hit, rsp_miss, ac_on;
  logic [51:0] rsp_paddr;
  logic [2:0]  rsp_fault;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  acg_top i_acg_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_kind(req_kind), .req_cpl(req_cpl),
    .req_stack(req_stack), .req_long(req_long), .mode_upd(mode_upd),
    .mode_cpl(mode_cpl), .mode_am(mode_am), .mode_ac(mode_ac),
    .mode_sysent(mode_sysent), .fill_en(fill_en), .fill_page(fill_page),
    .fill_frame(fill_frame), .fill_perm(fill_perm), .flush_all(flush_all),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .ac_on(ac_on)
  );

  // outcome code: 0 hit, 1 miss, 2 gp, 3 stack, 4 align
  localparam int O_HIT = 0, O_MISS = 1, O_GP = 2, O_SS = 3, O_AC = 4;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] code(input int o);
    code = 5'b00001 << o;
  endfunction

  task automatic access(input string req, input logic [63:0] a, input logic [1:0] sz,
                        input logic [1:0] kind, input logic [1:0] cpl, input logic stk,
                        input logic lng, input int exp_o, input logic [51:0] exp_pa);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_kind = kind;
    req_cpl = cpl; req_stack = stk; req_long = lng;
    @(negedge clk);
    check(req, {59'd0, rsp_fault[2], rsp_fault[1], rsp_fault[0], rsp_miss, rsp_hit},
          {59'd0, code(exp_o)});
    if (exp_o == O_HIT) check(req, {12'd0, rsp_paddr}, {12'd0, exp_pa});
    req_valid = 1'b0;
  endtask

  task automatic mode(input logic upd, input logic [1:0] cpl, input logic am,
                      input logic ac, input logic se);
    @(negedge clk);
    mode_upd = upd; mode_cpl = cpl; mode_am = am; mode_ac = ac; mode_sysent = se;
    @(negedge clk);
    mode_upd = 1'b0; mode_sysent = 1'b0;
  endtask

  task automatic fill(input logic [51:0] pg, input logic [39:0] fr, input logic [7:0] pm);
    @(negedge clk);
    fill_en = 1'b1; fill_page = pg; fill_frame = fr; fill_perm = pm;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 hit", {63'd0, rsp_hit}, 64'd0);
    check("R1 miss", {63'd0, rsp_miss}, 64'd0);
    check("R1 fault", {61'd0, rsp_fault}, 64'd0);
    check("R1 ac_on", {63'd0, ac_on}, 64'd0);
    access("R1 empty", 64'h0000_0000_0000_0000, 2'b00, 2'b00, 2'd0, 1'b0, 1'b0, O_MISS, '0);
  endtask

  task automatic t_hit_and_perm;
    fill(52'h0_0000_0001_2345, 40'h00_000A_BCDE, 8'h00);
    access("R4 read hit", 64'h0000_0000_1234_5678, 2'b10, 2'b00, 2'd3, 1'b0, 1'b1,
           O_HIT, 52'h000A_BCDE_678);
    access("R5 write no perm", 64'h0000_0000_1234_5678, 2'b10, 2'b01, 2'd3, 1'b0, 1'b1, O_MISS, '0);
    fill(52'h0_0000_0001_2345, 40'h00_000A_BCDE, 8'h90);
    access("R5 write cpl3", 64'h0000_0000_1234_5678, 2'b10, 2'b01, 2'd3, 1'b0, 1'b1,
           O_HIT, 52'h000A_BCDE_678);
    access("R5 rmw cpl0", 64'h0000_0000_1234_5678, 2'b10, 2'b10, 2'd0, 1'b0, 1'b1,
           O_HIT, 52'h000A_BCDE_678);
    access("R5 write cpl1", 64'h0000_0000_1234_5678, 2'b10, 2'b01, 2'd1, 1'b0, 1'b1, O_MISS, '0);
  endtask

  task automatic t_mode_rules;
    mode(1'b1, 2'd3, 1'b1, 1'b0, 1'b0);
    check("R2 ac clear", {63'd0, ac_on}, 64'd0);
    mode(1'b1, 2'd2, 1'b1, 1'b1, 1'b0);
    check("R2 cpl2", {63'd0, ac_on}, 64'd0);
    mode(1'b1, 2'd3, 1'b1, 1'b1, 1'b0);
    check("R2 enable", {63'd0, ac_on}, 64'd1);
    mode(1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R2 hold", {63'd0, ac_on}, 64'd1);
    mode(1'b1, 2'd3, 1'b1, 1'b1, 1'b1);
    check("R3 sysent wins", {63'd0, ac_on}, 64'd0);
  endtask

  task automatic t_alignment;
    mode(1'b1, 2'd3, 1'b1, 1'b1, 1'b0);
    access("R6 word misaligned", 64'h0000_0000_1234_5679, 2'b01, 2'b00, 2'd3, 1'b0, 1'b1, O_AC, '0);
    access("R6 dword aligned", 64'h0000_0000_1234_5678, 2'b10, 2'b00, 2'd3, 1'b0, 1'b1,
           O_HIT, 52'h000A_BCDE_678);
    access("R7 dword off2", 64'h0000_0000_1234_567A, 2'b10, 2'b00, 2'd3, 1'b0, 1'b1, O_AC, '0);
    access("R7 qword off4", 64'h0000_0000_1234_567C, 2'b11, 2'b00, 2'd3, 1'b0, 1'b1, O_AC, '0);
    access("R8 byte odd", 64'h0000_0000_1234_5679, 2'b00, 2'b00, 2'd3, 1'b0, 1'b1,
           O_HIT, 52'h000A_BCDE_679);
    mode(1'b1, 2'd3, 1'b0, 1'b1, 1'b0);
    access("R6 off misaligned hits", 64'h0000_0000_1234_5679, 2'b01, 2'b00, 2'd3, 1'b0, 1'b1,
           O_HIT, 52'h000A_BCDE_679);
  endtask

  task automatic t_canonical;
    mode(1'b1, 2'd3, 1'b1, 1'b1, 1'b0);
    access("R9 gp over align", 64'h0000_8000_0000_0001, 2'b01, 2'b00, 2'd3, 1'b0, 1'b1, O_GP, '0);
    access("R9 stack qword", 64'h0001_0000_0000_0000, 2'b11, 2'b01, 2'd3, 1'b1, 1'b0, O_SS, '0);
    access("R9 no check legacy", 64'h0000_8000_0000_0001, 2'b01, 2'b00, 2'd3, 1'b0, 1'b0, O_AC, '0);
    access("R9 upper canonical", 64'hFFFF_8000_0000_0000, 2'b11, 2'b00, 2'd3, 1'b0, 1'b1, O_MISS, '0);
    mode(1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
    access("R9 gp aligned", 64'h7FFF_0000_0000_0000, 2'b11, 2'b00, 2'd0, 1'b0, 1'b1, O_GP, '0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    check("R10 idle", {59'd0, rsp_fault, rsp_miss, rsp_hit}, 64'd0);
  endtask

  task automatic t_fill_flush;
    fill(52'h0_0000_0002_2345, 40'h00_0001_1111, 8'h00);
    access("R12 old page gone", 64'h0000_0000_1234_5000, 2'b10, 2'b00, 2'd0, 1'b0, 1'b1, O_MISS, '0);
    access("R12 new page hit", 64'h0000_0000_2234_5004, 2'b10, 2'b00, 2'd0, 1'b0, 1'b1,
           O_HIT, 52'h0001_1111_004);
    fill(52'h0_0000_0000_0007, 40'h00_0000_0777, 8'h00);
    @(negedge clk);
    flush_all = 1'b1; fill_en = 1'b1; fill_page = 52'h0_0000_0000_0008;
    fill_frame = 40'h1; fill_perm = 8'h0;
    @(negedge clk);
    flush_all = 1'b0; fill_en = 1'b0;
    access("R11 flush idx7", 64'h0000_0000_0000_7000, 2'b00, 2'b00, 2'd0, 1'b0, 1'b1, O_MISS, '0);
    access("R11 flush wins", 64'h0000_0000_0000_8000, 2'b00, 2'b00, 2'd0, 1'b0, 1'b1, O_MISS, '0);
    access("R11 flush idx5", 64'h0000_0000_2234_5000, 2'b00, 2'b00, 2'd0, 1'b0, 1'b1, O_MISS, '0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_kind = '0;
    req_cpl = '0; req_stack = 1'b0; req_long = 1'b0;
    mode_upd = 1'b0; mode_cpl = '0; mode_am = 1'b0; mode_ac = 1'b0; mode_sysent = 1'b0;
    fill_en = 1'b0; fill_page = '0; fill_frame = '0; fill_perm = '0; flush_all = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit_and_perm();
    t_mode_rules();
    t_alignment();
    t_canonical();
    t_idle();
    t_fill_flush();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule